// File: doc/BRIEF.md
# Context-Pointer Register Bank Unit

This block gives a processor core its general-purpose registers without holding them in flops. The registers live in a small word-organised RAM held inside the block. A context pointer register selects a 32-byte window in that RAM, and the window is the active bank. The bank holds sixteen 16-bit word registers. Sixteen byte registers overlay the low and high halves of the first eight word registers. Any single bit of any word in the bank can be read, set or cleared.

A context switch loads a new pointer. The old pointer comes out on a save port as a one-cycle strobe, so that the surrounding logic can push it. Banks can sit anywhere in the RAM and can overlap, so one storage location may appear under different register names in different banks. Requests arrive one per cycle on a single request port. A bit set or bit clear is a read followed by a write-back. It holds the port busy for one extra cycle.

Top module: `regbank_ctx`

## Requirements
- R1: A word read (op 3'd0) of register n addresses byte `cp + 2n` (reported on `ram_addr`). It returns the full 16-bit word on `rd_data`, with `rd_valid` high, in the cycle after the request.
- R2: A word write (op 3'd1) stores all 16 bits of `req_wdata` at word register n. A later read returns that value.
- R3: A byte read (op 3'd2) of byte register b addresses byte `cp + b`. Even b selects the low half (bits 7:0) of word register b/2 and odd b selects the high half (bits 15:8). The byte returns zero-extended in the cycle after the request.
- R4: A byte write (op 3'd3) replaces only the addressed half with `req_wdata[7:0]`. The other half of that word keeps its value.
- R5: A bit set (op 3'd5) or bit clear (op 3'd6) changes only bit `req_bit` of word register n. `busy` is high in the one cycle after the request. Any request presented while `busy` is high is ignored.
- R6: A bit read (op 3'd4) returns bit `req_bit` of word register n in `rd_data[0]`, with bits 15:1 zero, in the cycle after the request.
- R7: A context switch (op 3'd7) loads `req_cp` with bit 0 forced to zero into the pointer. In the next cycle `save_valid` is high for one cycle, `save_cp` holds the previous pointer, and any access made in that cycle already uses the new base.
- R8: Banks that overlap share storage. A value written through one pointer can be read at the same RAM location through another pointer.
- R9: After reset the pointer is zero, `busy`, `rd_valid` and `save_valid` are low, and every RAM word reads as zero.
- R10: Register addresses wrap modulo the RAM size, so a bank placed near the top of the RAM continues at address 0. No access ever falls outside `cp` through `cp + 1Eh` (modulo the RAM size).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R1 to R7) |
| req_reg | input | 4 | Word register number, or byte register number for byte ops |
| req_bit | input | 4 | Bit index for bit operations |
| req_wdata | input | 16 | Write data (bits 7:0 for byte writes) |
| req_cp | input | 8 | New pointer for a context switch |
| busy | output | 1 | Bit write-back in progress; requests ignored |
| ram_addr | output | 8 | Byte address of the presented register access |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Read result |
| cp_out | output | 8 | Current context pointer |
| save_valid | output | 1 | One-cycle strobe carrying the previous pointer |
| save_cp | output | 8 | Previous pointer, valid with `save_valid` |

## Verification
The assertions take for granted that `req_valid` is low during reset and that every input is stable around the rising edge. With that, every `$past` term refers to a cycle in which the request decode held real values. The bench drives all inputs on the falling edge and holds `req_valid` low while reset is asserted. It also puts requests into the busy cycle on purpose, because the design has to drop them rather than the stimulus avoiding them. All eight op codes are legal, so random op values need no filtering. Random pointers freely include odd values and values near the top of the RAM, which exercises the forced alignment and the wrap.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [2:0] {
    OP_WRD    = 3'd0,
    OP_WWR    = 3'd1,
    OP_BRD    = 3'd2,
    OP_BWR    = 3'd3,
    OP_XRD    = 3'd4,
    OP_XSET   = 3'd5,
    OP_XCLR   = 3'd6,
    OP_SWITCH = 3'd7
  } rb_op_e;

  typedef enum logic [1:0] {
    RK_WORD = 2'd0,
    RK_BYTE = 2'd1,
    RK_BIT  = 2'd2
  } rb_rkind_e;

  // offset of word register n inside the bank
  function automatic logic [4:0] word_offset(input logic [3:0] n);
    return {n, 1'b0};
  endfunction

  // byte register b sits at byte offset b (low half even, high half odd)
  function automatic logic [4:0] byte_offset(input logic [3:0] b);
    return {1'b0, b};
  endfunction

  function automatic logic [15:0] bit_apply(input logic [15:0] w,
                                            input logic [3:0]  idx,
                                            input logic        val);
    logic [15:0] r;
    r      = w;
    r[idx] = val;
    return r;
  endfunction

  function automatic logic [7:0] lane_pick(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

endpackage

// File: rtl/rb_addr_gen.sv
module rb_addr_gen
  import rb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] cp,
  input  rb_op_e            op,
  input  logic [3:0]        regn,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [ADDR_W-2:0] word_idx,
  output logic              hi_lane
);
  logic [4:0] off;

  always_comb begin
    if (op == OP_BRD || op == OP_BWR) off = byte_offset(regn);
    else                              off = word_offset(regn);
    byte_addr = cp + ADDR_W'(off);   // wraps modulo the RAM size
    word_idx  = byte_addr[ADDR_W-1:1];
    hi_lane   = byte_addr[0];
  end
endmodule

// File: rtl/rb_ram.sv
module rb_ram #(
  parameter int WORDS = 128,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             we,
  input  logic [1:0]       be,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rdata <= '0;
    end else if (en) begin
      if (we) begin
        if (be[0]) mem[idx][7:0]  <= wdata[7:0];
        if (be[1]) mem[idx][15:8] <= wdata[15:8];
      end else begin
        rdata <= mem[idx];
      end
    end
  end
endmodule

// File: rtl/rb_ctx.sv
module rb_ctx #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] new_cp,
  output logic [ADDR_W-1:0] cp,
  output logic              save_valid,
  output logic [ADDR_W-1:0] save_cp
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cp         <= '0;
      save_valid <= 1'b0;
      save_cp    <= '0;
    end else begin
      save_valid <= load;
      if (load) begin
        save_cp <= cp;
        cp      <= new_cp & ALIGN_MASK;
      end
    end
  end
endmodule

// File: rtl/regbank_ctx.sv
module regbank_ctx
  import rb_pkg::*;
#(
  parameter int RAM_BYTES = 256,
  localparam int ADDR_W = $clog2(RAM_BYTES),
  localparam int WORDS  = RAM_BYTES / 2,
  localparam int IDX_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [3:0]        req_reg,
  input  logic [3:0]        req_bit,
  input  logic [15:0]       req_wdata,
  input  logic [ADDR_W-1:0] req_cp,
  output logic              busy,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] cp_out,
  output logic              save_valid,
  output logic [ADDR_W-1:0] save_cp
);
  rb_op_e op;
  assign op = rb_op_e'(req_op);

  // named request events (also observed by the checker)
  logic accept, sw_accept, bitop_accept, read_accept, write_accept;
  logic pend_q;

  assign accept       = req_valid && !pend_q;
  assign sw_accept    = accept && op == OP_SWITCH;
  assign bitop_accept = accept && (op == OP_XSET || op == OP_XCLR);
  assign read_accept  = accept && (op == OP_WRD || op == OP_BRD || op == OP_XRD);
  assign write_accept = accept && (op == OP_WWR || op == OP_BWR);

  logic [IDX_W-1:0] word_idx;
  logic             hi_lane;

  rb_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .cp(cp_out), .op(op), .regn(req_reg),
    .byte_addr(ram_addr), .word_idx(word_idx), .hi_lane(hi_lane)
  );

  rb_ctx #(.ADDR_W(ADDR_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .load(sw_accept), .new_cp(req_cp),
    .cp(cp_out), .save_valid(save_valid), .save_cp(save_cp)
  );

  // pending bit write-back
  logic [IDX_W-1:0] pend_idx;
  logic [3:0]       pend_bit;
  logic             pend_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_idx <= '0;
      pend_bit <= '0;
      pend_val <= 1'b0;
    end else begin
      pend_q <= bitop_accept;
      if (bitop_accept) begin
        pend_idx <= word_idx;
        pend_bit <= req_bit;
        pend_val <= (op == OP_XSET);
      end
    end
  end
  assign busy = pend_q;

  // RAM port steering
  logic             m_en, m_we;
  logic [1:0]       m_be;
  logic [IDX_W-1:0] m_idx;
  logic [15:0]      m_wdata, m_rdata;

  always_comb begin
    if (pend_q) begin
      m_en    = 1'b1;
      m_we    = 1'b1;
      m_be    = 2'b11;
      m_idx   = pend_idx;
      m_wdata = bit_apply(m_rdata, pend_bit, pend_val);
    end else begin
      m_en    = read_accept || write_accept || bitop_accept;
      m_we    = write_accept;
      m_idx   = word_idx;
      if (op == OP_BWR) begin
        m_be    = hi_lane ? 2'b10 : 2'b01;
        m_wdata = {req_wdata[7:0], req_wdata[7:0]};
      end else begin
        m_be    = 2'b11;
        m_wdata = req_wdata;
      end
    end
  end

  rb_ram #(.WORDS(WORDS)) u_ram (
    .clk(clk), .rst_n(rst_n), .en(m_en), .we(m_we), .be(m_be),
    .idx(m_idx), .wdata(m_wdata), .rdata(m_rdata)
  );

  // read result formatting
  rb_rkind_e rk_q;
  logic      rd_hi_q;
  logic [3:0] rd_bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rk_q     <= RK_WORD;
      rd_hi_q  <= 1'b0;
      rd_bit_q <= '0;
    end else begin
      rd_valid <= read_accept;
      if (read_accept) begin
        rd_hi_q  <= hi_lane;
        rd_bit_q <= req_bit;
        case (op)
          OP_BRD:  rk_q <= RK_BYTE;
          OP_XRD:  rk_q <= RK_BIT;
          default: rk_q <= RK_WORD;
        endcase
      end
    end
  end

  always_comb begin
    case (rk_q)
      RK_BYTE: rd_data = {8'h00, lane_pick(m_rdata, rd_hi_q)};
      RK_BIT:  rd_data = {15'h0000, m_rdata[rd_bit_q]};
      default: rd_data = m_rdata;
    endcase
  end
endmodule

// File: rtl/rb_chk.sv
module rb_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rd_valid,
  input logic              save_valid,
  input logic [ADDR_W-1:0] save_cp,
  input logic [ADDR_W-1:0] cp_out,
  input logic [ADDR_W-1:0] req_cp,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic              bitop_accept,
  input logic              read_accept,
  input logic              sw_accept
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};
  logic [ADDR_W-1:0] win_off;
  assign win_off = ram_addr - cp_out;

  assert_busy_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $past(bitop_accept));
  assert_busy_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid);
  assert_rd_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(read_accept));
  assert_save_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid |-> ($past(sw_accept) && save_cp == $past(cp_out)));
  assert_cp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_accept |=> cp_out == ($past(req_cp) & ALIGN_MASK));
  assert_cp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_accept |=> $stable(cp_out));
  assert_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 3'd7) |-> win_off <= ADDR_W'(30));
endmodule

bind regbank_ctx rb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid),
  .save_valid(save_valid), .save_cp(save_cp), .cp_out(cp_out),
  .req_cp(req_cp), .ram_addr(ram_addr), .req_valid(req_valid),
  .req_op(req_op), .bitop_accept(bitop_accept),
  .read_accept(read_accept), .sw_accept(sw_accept)
);

// File: tb/regbank_ctx_bench.sv
`timescale 1ns/1ps
module regbank_ctx_bench;
  localparam int RB = 256;
  localparam int NW = RB / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [3:0] req_reg = '0, req_bit = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0] req_cp = '0;
  logic busy, rd_valid, save_valid;
  logic [7:0] ram_addr, cp_out, save_cp;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  regbank_ctx #(.RAM_BYTES(RB)) u_regbank_ctx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_reg(req_reg), .req_bit(req_bit), .req_wdata(req_wdata),
    .req_cp(req_cp), .busy(busy), .ram_addr(ram_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .cp_out(cp_out), .save_valid(save_valid),
    .save_cp(save_cp)
  );

  int checks = 0, fails = 0;
  logic [15:0] mdl_mem [NW];
  int mdl_cp = 0;
  bit mdl_busy = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R6"; 5, 6: return "R5"; default: return "R7";
    endcase
  endfunction

  // one request cycle; called right after a falling edge
  task automatic step(input bit v, input int op, input int r, input int b,
                      input int wd, input int ncp, input string tag);
    int a, w, hi, e_rd, old_cp;
    bit acc, e_rv, e_busy, e_sv;
    string t;
    t = (tag != "") ? tag : op_tag(op);
    req_valid = v; req_op = 3'(op); req_reg = 4'(r); req_bit = 4'(b);
    req_wdata = 16'(wd); req_cp = 8'(ncp);
    if (op == 2 || op == 3) a = (mdl_cp + r) % RB;
    else                    a = (mdl_cp + 2 * r) % RB;
    w = a / 2; hi = a % 2;
    #1;
    if (v && op != 7) chk({t, " ram_addr"}, ram_addr, a);
    acc = v && !mdl_busy;
    e_rv = 0; e_busy = 0; e_sv = 0; e_rd = 0; old_cp = mdl_cp;
    if (acc) begin
      case (op)
        0: begin e_rv = 1; e_rd = mdl_mem[w]; end
        1: mdl_mem[w] = 16'(wd);
        2: begin e_rv = 1; e_rd = hi ? mdl_mem[w][15:8] : mdl_mem[w][7:0]; end
        3: if (hi) mdl_mem[w][15:8] = 8'(wd); else mdl_mem[w][7:0] = 8'(wd);
        4: begin e_rv = 1; e_rd = int'(mdl_mem[w][b]); end
        5: begin e_busy = 1; mdl_mem[w][b] = 1'b1; end
        6: begin e_busy = 1; mdl_mem[w][b] = 1'b0; end
        default: begin e_sv = 1; mdl_cp = (ncp / 2) * 2; end
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    mdl_busy = e_busy;
    chk("R5 busy", busy, e_busy);
    chk({t, " rd_valid"}, rd_valid, e_rv);
    if (e_rv) chk({t, " rd_data"}, rd_data, e_rd);
    chk("R7 save_valid", save_valid, e_sv);
    if (e_sv) chk("R7 save_cp", save_cp, old_cp);
    chk("R7 cp_out", cp_out, mdl_cp);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) mdl_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9 busy", busy, 0);
    chk("R9 rd_valid", rd_valid, 0);
    chk("R9 save_valid", save_valid, 0);
    chk("R9 cp_out", cp_out, 0);
    step(1, 0, 5, 0, 0, 0, "R9");
    // R2 / R1: fill and read back bank 0
    for (int n = 0; n < 16; n++) step(1, 1, n, 0, 16'h1111 * n + 16'h0A05 + n, 0, "R2");
    for (int n = 0; n < 16; n++) step(1, 0, n, 0, 0, 0, "R1");
    // R3: every byte register
    for (int n = 0; n < 16; n++) step(1, 2, n, 0, 0, 0, "R3");
    // R4: byte writes keep the other half
    step(1, 3, 6, 0, 16'hBEEF, 0, "R4");
    step(1, 3, 11, 0, 16'h12C3, 0, "R4");
    step(1, 0, 3, 0, 0, 0, "R4");
    step(1, 0, 5, 0, 0, 0, "R4");
    // R5: bit set/clear, request during busy ignored
    step(1, 5, 9, 15, 0, 0, "R5");
    step(1, 0, 9, 0, 0, 0, "R5");
    step(1, 0, 9, 0, 0, 0, "R5");
    step(1, 6, 2, 0, 0, 0, "R5");
    step(1, 1, 2, 0, 16'hFFFF, 0, "R5");
    step(1, 0, 2, 0, 0, 0, "R5");
    // R6: bit reads
    step(1, 4, 9, 15, 0, 0, "R6");
    step(1, 4, 2, 0, 0, 0, "R6");
    step(1, 4, 4, 1, 0, 0, "R6");
    // R7: switch to odd pointer, access in the very next cycle
    step(1, 7, 0, 0, 0, 8'h21, "R7");
    step(1, 1, 0, 0, 16'h7A7A, 0, "R7");
    step(1, 7, 0, 0, 0, 8'h00, "R7");
    step(1, 0, 0, 0, 0, 0, "R7");
    // R8: overlapping bank at 0x10 aliases R8..R15 of bank 0
    step(1, 7, 0, 0, 0, 8'h10, "R8");
    step(1, 0, 0, 0, 0, 0, "R8");
    step(1, 1, 3, 0, 16'hC0DE, 0, "R8");
    step(1, 7, 0, 0, 0, 8'h00, "R8");
    step(1, 0, 11, 0, 0, 0, "R8");
    // R10: bank near the top wraps to address 0
    step(1, 7, 0, 0, 0, 8'hF8, "R10");
    step(1, 1, 7, 0, 16'h5AA5, 0, "R10");
    step(1, 2, 15, 0, 0, 0, "R10");
    step(1, 7, 0, 0, 0, 8'h00, "R10");
    step(1, 0, 3, 0, 0, 0, "R10");
    // mixed random traffic, including idle cycles
    for (int k = 0; k < 3000; k++) begin
      int op;
      op = $urandom_range(0, 7);
      if (op == 7 && $urandom_range(0, 3) != 0) op = 0;
      step($urandom_range(0, 9) != 0, op, $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 65535), $urandom_range(0, 255), "");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule